// File: doc/BRIEF.md
# Splittable Interval Timer with Match Interrupt

This block is a general-purpose interval timer that runs either as one 16-bit counter or as two independent 8-bit counters. A mode bit in the control register chooses between them. Each counter advances on a count tick and is compared with a reference value. When the counter already holds the reference value at a tick, the counter returns to zero, a sticky pending flag is set, and counting goes on. A match therefore occurs every reference+1 ticks.

The tick comes from one of several sources, chosen by a select field: the system clock divided by 512, 256, 64, 8 or 1, a sub-clock tick input, or an external clock pin that is synchronized inside the block. Software uses a small byte-wide register interface to configure the timer, poll or clear the pending flags, and read the running counts. Each interrupt request output is its pending flag gated by its own enable bit.

Top module: `ivt_top`

## Requirements
- R1: After reset every register reads 0: control at address 0, reference A at 1, reference B at 2, count A at 3, count B at 4, pending at 5. Both interrupt outputs are low.
- R2: Control bits [6:4] select the tick source. The codes are 0 for clock/512, 1 for /256, 2 for /64, 3 for /8, 4 for /1, 5 for the `subTick` input and 6 for the external clock. A free-running 9-bit prescaler starts at 0 after reset, and a divided tick comes in the cycle where its low log2(N) bits are all ones.
- R3: When control bit 7 is 1, the counters form one 16-bit count with A as the high byte and B as the low byte. On a tick, if the count equals {refA, refB}, the count becomes 0 and pending bit 0 is set. Otherwise the count increments. References 0x32 and 0x10 give a match at count 0x3210.
- R4: When control bit 7 is 0, counters A and B each run against their own reference. A match on A sets pending bit 0 and a match on B sets pending bit 1.
- R5: Writing control with bit 3 set clears both counters on that edge, and this takes priority over a tick and a match. Bit 3 always reads back as 0.
- R6: A pending bit is set on a match whether or not its interrupt is enabled, and hardware never clears it. Writing 0 to that bit at address 5 clears it. Writing 1 has no effect.
- R7: If a match and a software clear of the same pending bit fall on the same edge, the bit ends up set.
- R8: `irqA` is pending bit 0 AND control bit 1, and `irqB` is pending bit 1 AND control bit 0.
- R9: `extClk` passes through two synchronizer flops. Each rising edge then gives exactly one tick.
- R10: A reference write takes effect at the next comparison after the write edge. The count registers are read-only.
- R11: When control bit 2 (run) is 0, or when the select code is 7, the counters hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address for reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| subTick | input | 1 | Sub-clock tick, one cycle wide |
| extClk | input | 1 | External count clock, asynchronous |
| rdData | output | 8 | Combinational read data for `addr` |
| irqA | output | 1 | Interrupt request, timer A or the 16-bit timer |
| irqB | output | 1 | Interrupt request, timer B |

## Verification
Two functions can fall on the same edge: a counter match that sets a pending bit, and a software write of 0 that clears that bit. The bench provokes this by writing the clear on every cycle across several match periods with a short reference, so some write is sure to land exactly on the match edge. The behavioural model expects the flag to stay set after that edge, and `rdData` and `irqA`/`irqB` are compared with the model on every clock. A clear-counter write that lands on a match tick is exercised the same way, and the counter must then read zero with no pending bit raised.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  parameter int CNT_W  = 8;
  parameter int PSC_W  = 9;
  parameter int ADDR_W = 3;

  typedef struct packed {
    logic             tick;
    logic             clrCnt;
    logic             wide;
    logic [CNT_W-1:0] refA;
    logic [CNT_W-1:0] refB;
  } strobe_t;

  typedef enum logic [2:0] {
    SEL_D512 = 3'd0, SEL_D256 = 3'd1, SEL_D64 = 3'd2, SEL_D8 = 3'd3,
    SEL_D1 = 3'd4, SEL_SUB = 3'd5, SEL_EXT = 3'd6, SEL_OFF = 3'd7
  } clk_sel_e;
endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              subTick,
  input  logic              extClk,
  input  logic              matchA,
  input  logic              matchB,
  input  logic [CNT_W-1:0]  cntA,
  input  logic [CNT_W-1:0]  cntB,
  output strobe_t           strb,
  output logic [CNT_W-1:0]  rdData,
  output logic              irqA,
  output logic              irqB
);
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0, A_REFA = 3'd1, A_REFB = 3'd2,
                                A_CNTA = 3'd3, A_CNTB = 3'd4, A_PEND = 3'd5;

  logic             wideMode, runEn, ieA, ieB;
  clk_sel_e         clkSel;
  logic [CNT_W-1:0] refA, refB;
  logic             pendA, pendB;
  logic [PSC_W-1:0] psc;
  logic [2:0]       extSync;
  logic             extEdge, srcTick;
  logic             ctrlWr, pendWr;

  assign ctrlWr  = wrEn && (addr == A_CTRL);
  assign pendWr  = wrEn && (addr == A_PEND);
  assign extEdge = extSync[1] && !extSync[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psc     <= '0;
      extSync <= '0;
    end else begin
      psc     <= psc + 1'b1;
      extSync <= {extSync[1:0], extClk};
    end
  end

  always_comb begin
    unique case (clkSel)
      SEL_D512: srcTick = &psc[8:0];
      SEL_D256: srcTick = &psc[7:0];
      SEL_D64:  srcTick = &psc[5:0];
      SEL_D8:   srcTick = &psc[2:0];
      SEL_D1:   srcTick = 1'b1;
      SEL_SUB:  srcTick = subTick;
      SEL_EXT:  srcTick = extEdge;
      default:  srcTick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideMode <= 1'b0;
      clkSel   <= SEL_D512;
      runEn    <= 1'b0;
      ieA      <= 1'b0;
      ieB      <= 1'b0;
      refA     <= '0;
      refB     <= '0;
    end else if (wrEn) begin
      if (addr == A_CTRL) begin
        wideMode <= wrData[7];
        clkSel   <= clk_sel_e'(wrData[6:4]);
        runEn    <= wrData[2];
        ieA      <= wrData[1];
        ieB      <= wrData[0];
      end
      if (addr == A_REFA) refA <= wrData;
      if (addr == A_REFB) refB <= wrData;
    end
  end

  // set wins over a same-cycle software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendA <= 1'b0;
      pendB <= 1'b0;
    end else begin
      if (matchA)                      pendA <= 1'b1;
      else if (pendWr && !wrData[0])   pendA <= 1'b0;
      if (matchB)                      pendB <= 1'b1;
      else if (pendWr && !wrData[1])   pendB <= 1'b0;
    end
  end

  always_comb begin
    strb.tick   = runEn && srcTick;
    strb.clrCnt = ctrlWr && wrData[3];
    strb.wide   = wideMode;
    strb.refA   = refA;
    strb.refB   = refB;
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdData = {wideMode, clkSel, 1'b0, runEn, ieA, ieB};
      A_REFA:  rdData = refA;
      A_REFB:  rdData = refB;
      A_CNTA:  rdData = cntA;
      A_CNTB:  rdData = cntB;
      A_PEND:  rdData = {{(CNT_W-2){1'b0}}, pendB, pendA};
      default: rdData = '0;
    endcase
  end

  assign irqA = pendA && ieA;
  assign irqB = pendB && ieB;

  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    matchA |=> pendA);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    pendA && !(pendWr && !wrData[0]) |=> pendA);
  p_collide_r7: assert property (@(posedge clk) disable iff (!rstN)
    matchB && pendWr && !wrData[1] |=> pendB);
  p_ext_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    extEdge |=> !extEdge);
endmodule

// File: rtl/ivt_dpath.sv
module ivt_dpath
  import ivt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] cntA,
  output logic [CNT_W-1:0] cntB,
  output logic             matchA,
  output logic             matchB
);
  localparam int FULL_W = 2 * CNT_W;

  logic [FULL_W-1:0] fullCnt, fullRef;
  logic              hitWide, hitA, hitB, live;

  assign fullCnt = {cntA, cntB};
  assign fullRef = {strb.refA, strb.refB};
  assign live    = strb.tick && !strb.clrCnt;
  assign hitWide = fullCnt == fullRef;
  assign hitA    = cntA == strb.refA;
  assign hitB    = cntB == strb.refB;

  assign matchA = live && (strb.wide ? hitWide : hitA);
  assign matchB = live && !strb.wide && hitB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntA <= '0;
      cntB <= '0;
    end else if (strb.clrCnt) begin
      cntA <= '0;
      cntB <= '0;
    end else if (strb.tick) begin
      if (strb.wide) begin
        {cntA, cntB} <= hitWide ? '0 : fullCnt + 1'b1;
      end else begin
        cntA <= hitA ? '0 : cntA + 1'b1;
        cntB <= hitB ? '0 : cntB + 1'b1;
      end
    end
  end

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> (cntA == '0) && (cntB == '0));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    matchA && strb.wide |=> (cntA == '0) && (cntB == '0));
  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    live && !strb.wide && !matchB |=> cntB == CNT_W'($past(cntB) + 1'b1));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick && !strb.clrCnt |=> $stable(cntA) && $stable(cntB));
endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              subTick,
  input  logic              extClk,
  output logic [CNT_W-1:0]  rdData,
  output logic              irqA,
  output logic              irqB
);
  strobe_t          strb;
  logic [CNT_W-1:0] cntA, cntB;
  logic             matchA, matchB;

  ivt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .subTick(subTick), .extClk(extClk), .matchA(matchA), .matchB(matchB),
    .cntA(cntA), .cntB(cntB), .strb(strb), .rdData(rdData),
    .irqA(irqA), .irqB(irqB)
  );

  ivt_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cntA(cntA), .cntB(cntB),
    .matchA(matchA), .matchB(matchB)
  );
endmodule

// File: tb/sim_ivt_top.sv
`timescale 1ns/1ps
module sim_ivt_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic       subTick = 1'b0;
  logic       extClk = 1'b0;
  logic [7:0] rdData;
  logic       irqA, irqB;

  int nChk = 0, nFail = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ivt_top u0 (.clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
              .subTick(subTick), .extClk(extClk), .rdData(rdData),
              .irqA(irqA), .irqB(irqB));

  // behavioural reference state
  int mWide, mSel, mRun, mIeA, mIeB, mRa, mRb, mCa, mCb, mPa, mPb, mPsc, s1, s2, s3;

  task automatic modelReset();
    mWide = 0; mSel = 0; mRun = 0; mIeA = 0; mIeB = 0; mRa = 0; mRb = 0;
    mCa = 0; mCb = 0; mPa = 0; mPb = 0; mPsc = 0; s1 = 0; s2 = 0; s3 = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      int src, tick, clr, hitA, hitB, full, ref16;
      case (mSel)
        0: src = (mPsc % 512) == 511;
        1: src = (mPsc % 256) == 255;
        2: src = (mPsc % 64) == 63;
        3: src = (mPsc % 8) == 7;
        4: src = 1;
        5: src = subTick;
        6: src = s2 && !s3;
        default: src = 0;
      endcase
      tick = mRun && src;
      clr = wrEn && addr == 0 && wrData[3];
      hitA = 0; hitB = 0;
      if (clr) begin mCa = 0; mCb = 0; end
      else if (tick) begin
        if (mWide) begin
          full = mCa * 256 + mCb; ref16 = mRa * 256 + mRb;
          if (full == ref16) begin full = 0; hitA = 1; end
          else full = (full + 1) % 65536;
          mCa = full / 256; mCb = full % 256;
        end else begin
          if (mCa == mRa) begin mCa = 0; hitA = 1; end else mCa = (mCa + 1) % 256;
          if (mCb == mRb) begin mCb = 0; hitB = 1; end else mCb = (mCb + 1) % 256;
        end
      end
      if (hitA) mPa = 1; else if (wrEn && addr == 5 && !wrData[0]) mPa = 0;
      if (hitB) mPb = 1; else if (wrEn && addr == 5 && !wrData[1]) mPb = 0;
      if (wrEn && addr == 0) begin
        mWide = wrData[7]; mSel = wrData[6:4]; mRun = wrData[2];
        mIeA = wrData[1]; mIeB = wrData[0];
      end
      if (wrEn && addr == 1) mRa = wrData;
      if (wrEn && addr == 2) mRb = wrData;
      mPsc = (mPsc + 1) % 512;
      s3 = s2; s2 = s1; s1 = extClk;
    end
  end

  function automatic int expRd(int a);
    case (a)
      0: return mWide * 128 + mSel * 16 + mRun * 4 + mIeA * 2 + mIeB;
      1: return mRa;
      2: return mRb;
      3: return mCa;
      4: return mCb;
      5: return mPb * 2 + mPa;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", tag, cyc, act, exp);
    end
  endtask

  // compare against the model every clock, mid-cycle
  always @(posedge clk) begin
    cyc++;
    #3;
    if (!done) begin
      string tag;
      case (addr)
        0: tag = "R5 ctrl";
        1, 2: tag = "R10 ref";
        3, 4: tag = "R3 count";
        5: tag = "R6 pending";
        default: tag = "R1 unmapped";
      endcase
      chk(tag, rdData, expRd(addr));
      chk("R8 irqA", irqA, mPa && mIeA);
      chk("R8 irqB", irqB, mPb && mIeB);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); addr = a[2:0]; wrData = d[7:0]; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic watch(int a, int n);
    @(negedge clk); addr = a[2:0];
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    for (int a = 0; a < 8; a++) begin
      addr = a[2:0]; #1; chk("R1 reset read", rdData, 0);
    end
    chk("R1 irqA reset", irqA, 0); chk("R1 irqB reset", irqB, 0);
    rstN = 1'b1;

    // R3: 16-bit, div1, ref 0x0005
    wr(1, 8'h00); wr(2, 8'h05); wr(0, 8'hCE);
    watch(4, 20); watch(5, 2);
    // R6: write 1 keeps, write 0 clears
    wr(5, 8'hFF); watch(5, 1);
    wr(0, 8'h4E);  // narrow, ieA, stop? no: run
    wr(0, 8'hCE);
    // R7: clear written every cycle across matches
    @(negedge clk); addr = 3'd5; wrData = 8'h00; wrEn = 1'b1;
    repeat (20) @(negedge clk);
    wrEn = 1'b0;
    watch(5, 3);
    // R5: clear-counter write lands on a match tick at some point
    for (int k = 0; k < 8; k++) begin wr(0, 8'hCE); watch(3, k); end
    wr(5, 0);
    // R4: two 8-bit timers, refs 3 and 7, both interrupts enabled
    wr(1, 3); wr(2, 7); wr(0, 8'h4F);
    watch(3, 15); watch(4, 15); watch(5, 20);
    // R6: pending set with interrupts masked
    wr(5, 0); wr(0, 8'h4C); watch(5, 20);
    // R10: reference change mid-run
    wr(2, 2); watch(4, 10); wr(1, 9); watch(3, 25);
    // R11: run off, then select 7
    wr(0, 8'h4B); watch(3, 10); wr(0, 8'h77); watch(4, 10);
    // R2: divided sources
    wr(1, 0); wr(2, 1);
    for (int s = 0; s < 4; s++) begin
      wr(0, 8'h8E | (s << 4)); watch(4, 600); watch(5, 5);
    end
    // R2: sub-clock tick source
    wr(0, 8'hDE);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); addr = 3'd4; subTick = 1'b1;
      @(negedge clk); subTick = 1'b0;
      repeat (k % 3) @(negedge clk);
    end
    // R9: external clock, slow and then with narrow-cycle toggles
    wr(0, 8'hEE); wr(1, 0); wr(2, 2);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); addr = (k % 2) ? 3'd5 : 3'd4; extClk = 1'b1;
      repeat (2 + k % 3) @(negedge clk); extClk = 1'b0;
      repeat (3) @(negedge clk);
    end
    watch(4, 6);
    // R3: the 0x3210 example at div1, and control write 0x8E readback
    wr(5, 0); wr(1, 8'h32); wr(2, 8'h10); wr(0, 8'hCE);
    watch(3, 12000);
    chk("R3 no match before 0x3210", irqA, 0);
    watch(4, 830);
    chk("R3 match at 0x3210 raised irqA", irqA, 1);
    wr(0, 8'h8E); watch(0, 3);
    chk("R5 ctrl readback of 0x8E", rdData, 8'h86);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule